// File: doc/BRIEF.md
# Two-Port PS/2 Receive Controller

This block receives serial bytes from two PS/2 devices at once, typically a keyboard on one port and a mouse on the other. The device drives the serial clock at roughly 10 kHz. The block brings each clock and data line into the system clock domain through a two-stage synchroniser and samples data on every falling edge of the synchronised clock. It rebuilds 11-bit frames, checks them, and stores each accepted byte in a receive queue of its own per port. The queues are deep enough that the host can read at its own pace. Keyboard break sequences (0xF0, then the scan code) and 3- or 4-byte mouse reports pass through untouched, one byte per queue entry.

The host side is a small register file with an address, a read strobe and a write strobe. Reading a data register removes the oldest byte from that port's queue. Each port has a status register of sticky event flags, which the host clears by writing 1s. A shared configuration register selects which events of which port drive the single interrupt output. `FIFO_AW` sets the queue depth to `2**FIFO_AW` entries, 256 by default. `TIMEOUT_CYC` sets the mid-frame inactivity limit in system clocks; the default is about 2 ms at 125 MHz.

Top module: `dual_ps2_rx`

## Requirements
- R1: After reset, every status and configuration register reads 0x00, both queues are empty, and `irq` is low.
- R2: A frame is a 0 start bit, then 8 data bits with the least significant bit first, then an odd parity bit, then a 1 stop bit. Each bit is sampled on a falling edge of the device clock. A valid frame appends its byte to the port's queue and sets status bit 1 (byte received).
- R3: Data register reads return bytes in arrival order and leave their values unchanged, including 0xF0. Each queue holds 256 bytes.
- R4: A frame whose parity is even sets status bit 3 and queues nothing.
- R5: A frame whose stop bit is 0 sets status bit 4 and queues nothing.
- R6: Inside a frame, if the device clock stays high for more than `TIMEOUT_CYC` cycles, status bit 2 is set and the partial frame is discarded. The next frame after that is received normally.
- R7: A valid byte that arrives while its queue is full is dropped, and status bit 5 (overflow) is set. The stored contents are not changed.
- R8: Status bit 0 shows live that the queue is not empty. Writing the status register clears each of bits 1 to 5 whose written bit is 1 and leaves the others as they are.
- R9: Register map. Address 0 and address 1 are the data registers of port 0 and port 1. Address 2 and address 3 are their status registers. Address 4 is the read/write configuration register. Bits [3:0] of the configuration register serve port 0 and bits [7:4] serve port 1. Within each nibble, bit 0 enables byte received, bit 1 enables timeout, bit 2 enables parity or stop error, and bit 3 enables overflow.
- R10: `irq` is the OR of every set status flag whose enable bit is set.
- R11: The two ports are independent: traffic on one port changes neither the status nor the queue of the other.
- R12: Reading an empty data register returns 0x00 and leaves the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kclk_i | input | 2 | Device clock line, one per port |
| kdat_i | input | 2 | Device data line, one per port |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Read strobe; pops the queue when the address selects a data register |
| reg_rdata | output | 8 | Read data for the register at `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a completed frame with bad parity, a bad stop bit or a full queue sets its flag in the next cycle;
- a dropped byte leaves the write pointer where it was;
- a timeout returns the receiver to idle;
- a read of an empty queue leaves the read pointer where it was;
- an all-zero configuration keeps `irq` low.

Only the bench scenarios can show the byte values in LSB-first order, queue ordering over a full 256-byte fill, recovery after a timeout, write-1-to-clear behaviour, and the independence of the two ports.

// File: rtl/dual_ps2_rx.sv
module dual_ps2_rx #(
  parameter int FIFO_AW     = 8,
  parameter int TIMEOUT_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] kclk_i,
  input  logic [1:0] kdat_i,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int TW    = $clog2(TIMEOUT_CYC + 1);
  localparam int PW    = FIFO_AW + 1;
  localparam int DEPTH = 1 << FIFO_AW;

  logic [1:0][2:0]    ck_s;
  logic [1:0][1:0]    dt_s;
  logic [1:0][3:0]    bcnt;
  logic [1:0][8:0]    sh;
  logic [1:0][TW-1:0] tcnt;
  logic [1:0][PW-1:0] wp, rp;
  logic [1:0][4:0]    flg;
  logic [1:0][7:0]    head, stat;
  logic [1:0]         fall, done, par_ok, stop_ok, tmo, push, pop, full, empty, pend;
  logic [7:0]         cfg;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [7:0] mem [DEPTH];
    logic [4:0] clr, set;
    logic [3:0] en;

    assign fall[c]    = ck_s[c][2] & ~ck_s[c][1];
    assign done[c]    = fall[c] && bcnt[c] == 4'd10;
    assign par_ok[c]  = ^sh[c];
    assign stop_ok[c] = dt_s[c][1];
    assign tmo[c]     = (bcnt[c] != 4'd0) && ck_s[c][1] && tcnt[c] == TW'(TIMEOUT_CYC);
    assign full[c]    = (wp[c] ^ rp[c]) == {1'b1, {FIFO_AW{1'b0}}};
    assign empty[c]   = wp[c] == rp[c];
    assign push[c]    = done[c] & par_ok[c] & stop_ok[c] & ~full[c];
    assign pop[c]     = reg_rd && reg_addr == 3'(c) && !empty[c];
    assign head[c]    = empty[c] ? 8'h00 : mem[rp[c][FIFO_AW-1:0]];
    assign stat[c]    = {2'b00, flg[c], ~empty[c]};

    assign clr = (reg_wr && reg_addr == 3'(2 + c)) ? reg_wdata[5:1] : 5'd0;
    assign set = {done[c] & par_ok[c] & stop_ok[c] & full[c],
                  done[c] & ~stop_ok[c], done[c] & ~par_ok[c], tmo[c], push[c]};
    assign en      = cfg[4*c +: 4];
    assign pend[c] = |(flg[c] & {en[3], en[2], en[2], en[1], en[0]});

    always_ff @(posedge clk) if (push[c]) mem[wp[c][FIFO_AW-1:0]] <= sh[c][7:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ck_s[c] <= 3'b111;
        dt_s[c] <= 2'b11;
        bcnt[c] <= '0;
        sh[c]   <= '0;
        tcnt[c] <= '0;
        wp[c]   <= '0;
        rp[c]   <= '0;
        flg[c]  <= '0;
      end else begin
        ck_s[c] <= {ck_s[c][1:0], kclk_i[c]};
        dt_s[c] <= {dt_s[c][0], kdat_i[c]};
        if (tmo[c]) bcnt[c] <= '0;
        else if (fall[c]) begin
          if (bcnt[c] == 4'd0) begin
            if (!dt_s[c][1]) bcnt[c] <= 4'd1;
          end else if (bcnt[c] == 4'd10) bcnt[c] <= '0;
          else begin
            sh[c]   <= {dt_s[c][1], sh[c][8:1]};
            bcnt[c] <= bcnt[c] + 4'd1;
          end
        end
        if (bcnt[c] == 4'd0 || !ck_s[c][1]) tcnt[c] <= '0;
        else if (tcnt[c] != TW'(TIMEOUT_CYC)) tcnt[c] <= tcnt[c] + 1'b1;
        wp[c]  <= wp[c] + PW'(push[c]);
        rp[c]  <= rp[c] + PW'(pop[c]);
        flg[c] <= (flg[c] & ~clr) | set;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (reg_wr && reg_addr == 3'd4) cfg <= reg_wdata;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = head[0];
      3'd1:    reg_rdata = head[1];
      3'd2:    reg_rdata = stat[0];
      3'd3:    reg_rdata = stat[1];
      3'd4:    reg_rdata = cfg;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = |pend;
endmodule

// File: rtl/dual_ps2_rx_chk.sv
module dual_ps2_rx_chk #(
  parameter int PW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq,
  input logic [7:0]     cfg,
  input logic [2:0]     reg_addr,
  input logic           reg_rd,
  input logic [1:0]     done,
  input logic [1:0]     par_ok,
  input logic [1:0]     stop_ok,
  input logic [1:0]     tmo,
  input logic [1:0]     full,
  input logic [1:0]     empty,
  input logic [7:0]     bcnt_flat,
  input logic [9:0]     flg_flat,
  input logic [2*PW-1:0] wp_flat,
  input logic [2*PW-1:0] rp_flat
);
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 8'h00) |-> !irq);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    p_parity_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && !par_ok[c]) |=> flg_flat[5*c+2]);
    p_stop_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && !stop_ok[c]) |=> flg_flat[5*c+3]);
    p_timeout_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tmo[c] |=> (bcnt_flat[4*c +: 4] == 4'd0) && flg_flat[5*c+1]);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && par_ok[c] && stop_ok[c] && full[c]) |=> flg_flat[5*c+4] && $stable(wp_flat[PW*c +: PW]));
    p_empty_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'(c) && empty[c]) |=> $stable(rp_flat[PW*c +: PW]));
  end
endmodule

bind dual_ps2_rx dual_ps2_rx_chk #(.PW(FIFO_AW + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .cfg(cfg), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .done(done), .par_ok(par_ok), .stop_ok(stop_ok), .tmo(tmo), .full(full), .empty(empty),
  .bcnt_flat(bcnt), .flg_flat(flg), .wp_flat(wp), .rp_flat(rp)
);

// File: tb/dual_ps2_rx_tb.sv
module dual_ps2_rx_tb;
  localparam int HP  = 8;
  localparam int TMO = 64;

  logic       clk = 0, rst_n = 0;
  logic [1:0] kclk_i = 2'b11, kdat_i = 2'b11;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq;
  int         n_run = 0, n_fail = 0;
  bit         finished = 0;

  dual_ps2_rx #(.FIFO_AW(8), .TIMEOUT_CYC(TMO)) u_dut (.*);

  always #4 clk = ~clk;

  // {channel, byte, force bad parity, stop bit}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 8'hF0, 1'b0, 1'b1}, {1'b0, 8'h1C, 1'b0, 1'b1},
    {1'b1, 8'h08, 1'b0, 1'b1}, {1'b1, 8'h05, 1'b0, 1'b1},
    {1'b1, 8'hFD, 1'b0, 1'b1}, {1'b0, 8'h3A, 1'b1, 1'b1},
    {1'b1, 8'h81, 1'b0, 1'b0}, {1'b0, 8'h00, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int ch, input logic [7:0] b, input bit badpar, input bit stopv, input int nbits);
    logic [10:0] f;
    f = {stopv, (~^b) ^ badpar, b, 1'b0};
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk) kdat_i[ch] = f[k];
      repeat (HP/2) @(negedge clk);
      kclk_i[ch] = 1'b0;
      repeat (HP) @(negedge clk);
      kclk_i[ch] = 1'b1;
      repeat (HP/2) @(negedge clk);
    end
    kdat_i[ch] = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input bit popit, output logic [7:0] d);
    @(negedge clk) reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = popit;
    @(negedge clk) reg_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk) begin reg_addr = a; reg_wdata = d; reg_wr = 1; end
    @(negedge clk) reg_wr = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, exp_st;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int a = 0; a < 5; a++) begin
      rd(3'(a), 0, d);
      check(d == 8'h00, "R1 reset register", d, 0);
    end
    check(irq == 0, "R1 reset irq", irq, 0);

    foreach (VEC[i]) begin
      int ch; bit good;
      ch = VEC[i][10];
      good = !VEC[i][1] && VEC[i][0];
      send(ch, VEC[i][9:2], VEC[i][1], VEC[i][0], 11);
      exp_st = good ? 8'h03 : {3'b000, ~VEC[i][0], VEC[i][1], 3'b000};
      rd(3'(2 + ch), 0, d);
      check(d == exp_st, good ? "R2 status after good frame" : "R4/R5 error status", d, exp_st);
      rd(3'(3 - ch), 0, d);
      check(d == 8'h00, "R11 other port untouched", d, 0);
      rd(3'(ch), 1, d);
      check(d == (good ? VEC[i][9:2] : 8'h00), good ? "R2 byte value" : "R4/R5 byte not queued", d, good ? VEC[i][9:2] : 0);
      wr(3'(2 + ch), 8'hFF);
      rd(3'(2 + ch), 0, d);
      check(d == 8'h00, "R8 write-1 clear", d, 0);
    end

    send(0, 8'hF0, 0, 1, 11);
    send(0, 8'h2B, 0, 1, 11);
    send(0, 8'h12, 0, 1, 11);
    wr(3'd2, 8'h04);
    rd(3'd2, 0, d);
    check(d == 8'h03, "R8 writing 0 bits keeps flag", d, 8'h03);
    rd(3'd0, 1, d); check(d == 8'hF0, "R3 order 1st", d, 8'hF0);
    rd(3'd0, 1, d); check(d == 8'h2B, "R3 order 2nd", d, 8'h2B);
    rd(3'd0, 1, d); check(d == 8'h12, "R3 order 3rd", d, 8'h12);
    rd(3'd2, 0, d); check(d == 8'h02, "R8 empty bit clears", d, 8'h02);
    wr(3'd2, 8'hFF);

    send(0, 8'hA5, 0, 1, 4);
    repeat (TMO + 20) @(negedge clk);
    rd(3'd2, 0, d);
    check(d == 8'h04, "R6 timeout flag, nothing queued", d, 8'h04);
    wr(3'd2, 8'hFF);
    send(0, 8'h6E, 0, 1, 11);
    rd(3'd0, 1, d);
    check(d == 8'h6E, "R6 recovery after timeout", d, 8'h6E);
    wr(3'd2, 8'hFF);

    wr(3'd4, 8'h01);
    rd(3'd4, 0, d);
    check(d == 8'h01, "R9 config readback", d, 8'h01);
    send(1, 8'h11, 0, 1, 11);
    check(irq == 0, "R10 masked port no irq", irq, 0);
    send(0, 8'h22, 0, 1, 11);
    check(irq == 1, "R10 enabled rx raises irq", irq, 1);
    wr(3'd2, 8'h02);
    check(irq == 0, "R10 clear drops irq", irq, 0);
    wr(3'd4, 8'h40);
    send(0, 8'h33, 1, 1, 11);
    check(irq == 0, "R10 other port error masked", irq, 0);
    send(1, 8'h44, 1, 1, 11);
    check(irq == 1, "R10 port1 error irq", irq, 1);
    wr(3'd4, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    rd(3'd0, 1, d); rd(3'd1, 1, d);
    check(d == 8'h11, "R11 port1 queue kept its byte", d, 8'h11);

    for (int i = 0; i < 257; i++) send(1, 8'(i) ^ 8'h5A, 0, 1, 11);
    rd(3'd3, 0, d);
    check(d == 8'h23, "R7 overflow flag", d, 8'h23);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) begin
        rd(3'd1, 1, d);
        if (d != (8'(i) ^ 8'h5A)) bad++;
      end
      check(bad == 0, "R3 256 bytes in order", bad, 0);
    end
    rd(3'd1, 1, d);
    check(d == 8'h00, "R12 empty read returns 0", d, 0);
    rd(3'd3, 0, d);
    check(d == 8'h22, "R12 queue stays empty", d, 8'h22);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule